// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block manages 64 general-purpose pins arranged as two 32-bit banks. For each pin it holds three settings: a direction bit, a function-select bit and an output value. It also reports the pin's current input level. Software reaches all of this through a small word-addressed register bus. A write takes effect at the clock edge that samples it. A read returns data combinationally from the addressed register. The block does not drive pads itself. It presents a pad-enable vector, a pad-data vector and an alternate-function select vector to the pad ring.

The lowest sixteen pins can raise interrupts. Each of these pins has three independent configuration bits: edge, high and low. Together they select a detection mode:

- low level
- high level
- rising edge
- falling edge
- either edge
- no detection

Each pin also has an enable bit and a clear bit. Software acknowledges a request by writing its clear bit to one and then back to zero. Writing all sixteen clear bits at once clears every request. A single registered interrupt line is the OR of all enabled pending requests.

Every pin input passes through a two-flop synchronizer. The readable input value and the edge detectors both work on this synchronized copy.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n with n < 32 maps to bit n of the first-bank registers. Pin n with n >= 32 maps to bit n-32 of the second-bank registers. The word offsets are: direction 0/1, select 2/3, output 4/5, input 6/7.
- R2: A direction bit of 1 drives `pin_oe` high for that pin and 0 drives it low. After reset every pin is an input.
- R3: A select bit of 1 drives `alt_sel` high for that pin and 0 leaves it low (GPIO). After reset all select bits are 0.
- R4: The output registers drive `pin_out` bit for bit.
- R5: The input registers read the pin level two clock edges after it changes, through a two-flop synchronizer. Writes to offsets 6 and 7 are ignored.
- R6: Interrupt-capable pins are pins 0..15, and pin i uses bit i of offsets 8 (edge), 9 (high), 10 (low), 11 (clear), 12 (enable) and 13 (status). With {edge,high,low} = 001 the request is pending while the synchronized level is 0. With 010 it is pending while the level is 1. A level request is not sticky.
- R7: With {edge,high,low} = 110 a rising edge of the synchronized level sets a sticky pending flag. With 101 a falling edge sets it, and with 111 either edge sets it. Each flag is set one edge after the synchronized value changes. The codes 000, 011 and 100 never set a pending flag.
- R8: While a clear bit is 1, its pending flag reads 0 and new events are not latched. Writing 0xFFFF to offset 11 and then 0 clears all pending flags.
- R9: `irq` is a register that holds the OR, over all pins, of pending AND enable as it stood one edge earlier. With every enable at 0, `irq` stays 0.
- R10: Reset zeroes every register: direction, select, output, edge, high, low, clear and enable. It also zeroes all pending flags and `irq`.
- R11: Offset 13 reads the pending flags in bits 15:0 and ignores writes. Offsets 14 and 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 64 | Raw pad input levels |
| pin_out | output | 64 | Pad output data |
| pin_oe | output | 64 | Pad output enable (1 = output) |
| alt_sel | output | 64 | Alternate-function select (1 = alternate) |
| irq | output | 1 | Combined registered interrupt |

## Verification
The configuration outputs follow the edge that captures a write, so they are due at the next falling edge. An input change is visible in the input register after two edges. A level or edge request appears in the status word after three edges, and `irq` follows one edge later. The bench drives stimulus shortly after a rising edge. It advances a behavioural reference model on that same rising edge, and compares every output and the addressed read data at each falling edge. Each per-cycle comparison therefore lands exactly in the cycle where the result is due. The directed checks wait a margin past these latencies before they look for a settled value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int OFS_W = 4;

   // Word offsets of the register bus. The bank order (first bank at the even
   // offset) is decoded by the register file and relied on by software.
   typedef enum logic [OFS_W-1:0] {
      REG_DIR0  = 4'd0,
      REG_DIR1  = 4'd1,
      REG_SEL0  = 4'd2,
      REG_SEL1  = 4'd3,
      REG_OUT0  = 4'd4,
      REG_OUT1  = 4'd5,
      REG_IN0   = 4'd6,
      REG_IN1   = 4'd7,
      REG_IEDGE = 4'd8,
      REG_IHIGH = 4'd9,
      REG_ILOW  = 4'd10,
      REG_ICLR  = 4'd11,
      REG_IEN   = 4'd12,
      REG_ISTAT = 4'd13
   } reg_ofs_e;

   typedef enum logic [2:0] {
      DET_NONE,
      DET_LVL_LO,
      DET_LVL_HI,
      DET_RISE,
      DET_FALL,
      DET_BOTH
   } det_kind_e;

   // Translate the three independent configuration bits into a detector kind.
   function automatic det_kind_e decode_det(input logic e, input logic h, input logic l);
      case ({e, h, l})
         3'b001:  return DET_LVL_LO;
         3'b010:  return DET_LVL_HI;
         3'b110:  return DET_RISE;
         3'b101:  return DET_FALL;
         3'b111:  return DET_BOTH;
         default: return DET_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      end else begin
         chain[0] <= d;
         for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
   import gpio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic lvl_d,
   input  logic cfg_edge,
   input  logic cfg_high,
   input  logic cfg_low,
   input  logic clr,
   output logic pend
);

   det_kind_e kind;
   logic      rise, fall, pend_nxt;

   assign kind = decode_det(cfg_edge, cfg_high, cfg_low);
   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;

   always_comb begin
      case (kind)
         DET_LVL_LO: pend_nxt = ~lvl;
         DET_LVL_HI: pend_nxt = lvl;
         DET_RISE:   pend_nxt = pend | rise;
         DET_FALL:   pend_nxt = pend | fall;
         DET_BOTH:   pend_nxt = pend | rise | fall;
         default:    pend_nxt = 1'b0;
      endcase
      if (clr) pend_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_nxt;
   end

   // R8: a held clear bit keeps the flag low on the following cycle
   a_r8_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !pend);

   // R7: an edge-mode flag is sticky until cleared
   a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((kind == DET_RISE || kind == DET_FALL || kind == DET_BOTH) && pend && !clr) |=> pend);

   // R6: a high-level request tracks the synchronized level
   a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == DET_LVL_HI && !clr) |=> (pend == $past(lvl)));

   // R7: unlisted codes never raise a request
   a_r7_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == DET_NONE) |=> !pend);

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int BANK_W  = 32,
   parameter int NUM_IRQ = 16,
   parameter int DATA_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OFS_W-1:0]     addr,
   input  logic                 wr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [2*BANK_W-1:0]  in_sync,
   input  logic [NUM_IRQ-1:0]   pend,
   output logic [2*BANK_W-1:0]  dir_o,
   output logic [2*BANK_W-1:0]  sel_o,
   output logic [2*BANK_W-1:0]  out_o,
   output logic [NUM_IRQ-1:0]   iedge_o,
   output logic [NUM_IRQ-1:0]   ihigh_o,
   output logic [NUM_IRQ-1:0]   ilow_o,
   output logic [NUM_IRQ-1:0]   iclr_o,
   output logic [NUM_IRQ-1:0]   ien_o
);

   localparam int NBANK = 2;

   // Per-bank direction, select and output registers
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam logic [OFS_W-1:0] A_DIR = OFS_W'(int'(REG_DIR0) + b);
      localparam logic [OFS_W-1:0] A_SEL = OFS_W'(int'(REG_SEL0) + b);
      localparam logic [OFS_W-1:0] A_OUT = OFS_W'(int'(REG_OUT0) + b);

      logic [BANK_W-1:0] dir_b, sel_b, out_b;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dir_b <= '0;
            sel_b <= '0;
            out_b <= '0;
         end else if (wr) begin
            if (addr == A_DIR) dir_b <= wdata[BANK_W-1:0];
            if (addr == A_SEL) sel_b <= wdata[BANK_W-1:0];
            if (addr == A_OUT) out_b <= wdata[BANK_W-1:0];
         end
      end

      assign dir_o[b*BANK_W +: BANK_W] = dir_b;
      assign sel_o[b*BANK_W +: BANK_W] = sel_b;
      assign out_o[b*BANK_W +: BANK_W] = out_b;
   end

   // Interrupt configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iedge_o <= '0;
         ihigh_o <= '0;
         ilow_o  <= '0;
         iclr_o  <= '0;
         ien_o   <= '0;
      end else if (wr) begin
         case (addr)
            REG_IEDGE: iedge_o <= wdata[NUM_IRQ-1:0];
            REG_IHIGH: ihigh_o <= wdata[NUM_IRQ-1:0];
            REG_ILOW:  ilow_o  <= wdata[NUM_IRQ-1:0];
            REG_ICLR:  iclr_o  <= wdata[NUM_IRQ-1:0];
            REG_IEN:   ien_o   <= wdata[NUM_IRQ-1:0];
            default: ;
         endcase
      end
   end

   // Read multiplexer
   always_comb begin
      rdata = '0;
      case (addr)
         REG_DIR0:  rdata[BANK_W-1:0]  = dir_o[BANK_W-1:0];
         REG_DIR1:  rdata[BANK_W-1:0]  = dir_o[2*BANK_W-1:BANK_W];
         REG_SEL0:  rdata[BANK_W-1:0]  = sel_o[BANK_W-1:0];
         REG_SEL1:  rdata[BANK_W-1:0]  = sel_o[2*BANK_W-1:BANK_W];
         REG_OUT0:  rdata[BANK_W-1:0]  = out_o[BANK_W-1:0];
         REG_OUT1:  rdata[BANK_W-1:0]  = out_o[2*BANK_W-1:BANK_W];
         REG_IN0:   rdata[BANK_W-1:0]  = in_sync[BANK_W-1:0];
         REG_IN1:   rdata[BANK_W-1:0]  = in_sync[2*BANK_W-1:BANK_W];
         REG_IEDGE: rdata[NUM_IRQ-1:0] = iedge_o;
         REG_IHIGH: rdata[NUM_IRQ-1:0] = ihigh_o;
         REG_ILOW:  rdata[NUM_IRQ-1:0] = ilow_o;
         REG_ICLR:  rdata[NUM_IRQ-1:0] = iclr_o;
         REG_IEN:   rdata[NUM_IRQ-1:0] = ien_o;
         REG_ISTAT: rdata[NUM_IRQ-1:0] = pend;
         default:   rdata = '0;
      endcase
   end

   // R2: a write to a non-direction offset leaves the pad enables untouched
   a_r2_dir_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || (addr != REG_DIR0 && addr != REG_DIR1)) |=> $stable(dir_o));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int BANK_W      = 32,
   parameter int NUM_IRQ     = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [3:0]           reg_addr,
   input  logic                 reg_wr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [2*BANK_W-1:0]  pin_in,
   output logic [2*BANK_W-1:0]  pin_out,
   output logic [2*BANK_W-1:0]  pin_oe,
   output logic [2*BANK_W-1:0]  alt_sel,
   output logic                 irq
);

   localparam int NUM_PINS = 2 * BANK_W;

   // Elaboration-time parameter checks
   if (BANK_W > DATA_W) begin : g_chk_bank
      $error("gpio_irq_ctrl: BANK_W must not exceed DATA_W");
   end
   if (NUM_IRQ > BANK_W || NUM_IRQ < 1) begin : g_chk_irq
      $error("gpio_irq_ctrl: NUM_IRQ must be 1..BANK_W");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("gpio_irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_IRQ-1:0]  lvl_prev;
   logic [NUM_IRQ-1:0]  pend;
   logic [NUM_IRQ-1:0]  cfg_edge, cfg_high, cfg_low, cfg_clr, cfg_en;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_regs #(.BANK_W(BANK_W), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (reg_addr),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .in_sync (pin_sync),
      .pend    (pend),
      .dir_o   (pin_oe),
      .sel_o   (alt_sel),
      .out_o   (pin_out),
      .iedge_o (cfg_edge),
      .ihigh_o (cfg_high),
      .ilow_o  (cfg_low),
      .iclr_o  (cfg_clr),
      .ien_o   (cfg_en)
   );

   // Previous synchronized level, kept only for interrupt-capable pins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= '0;
      else        lvl_prev <= pin_sync[NUM_IRQ-1:0];
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
      gpio_irq_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl      (pin_sync[i]),
         .lvl_d    (lvl_prev[i]),
         .cfg_edge (cfg_edge[i]),
         .cfg_high (cfg_high[i]),
         .cfg_low  (cfg_low[i]),
         .clr      (cfg_clr[i]),
         .pend     (pend[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(pend & cfg_en);
   end

   // R9: no enabled request means no interrupt on the next cycle
   a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (~|(pend & cfg_en)) |=> !irq);

   // R9: an enabled request raises the line one cycle later
   a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend & cfg_en)) |=> irq);

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] pin_in = '0;
   logic [63:0] pin_out, pin_oe, alt_sel;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_irq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .alt_sel   (alt_sel),
      .irq       (irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_s1 = '0, m_s2 = '0, m_dir = '0, m_sel = '0, m_out = '0;
   logic [15:0] m_prev = '0, m_edge = '0, m_hi = '0, m_lo = '0;
   logic [15:0] m_clr = '0, m_en = '0, m_pend = '0;
   logic        m_irq = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      logic [15:0] np;
      logic        ni;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_dir = '0; m_sel = '0; m_out = '0;
         m_prev = '0; m_edge = '0; m_hi = '0; m_lo = '0;
         m_clr = '0; m_en = '0; m_pend = '0; m_irq = 1'b0;
      end else begin
         for (int i = 0; i < 16; i++) begin
            int code;
            code = {m_edge[i], m_hi[i], m_lo[i]};
            if (m_clr[i]) np[i] = 1'b0;
            else case (code)
               1: np[i] = !m_s2[i];
               2: np[i] = m_s2[i];
               6: np[i] = m_pend[i] | (m_s2[i] & !m_prev[i]);
               5: np[i] = m_pend[i] | (!m_s2[i] & m_prev[i]);
               7: np[i] = m_pend[i] | (m_s2[i] != m_prev[i]);
               default: np[i] = 1'b0;
            endcase
         end
         ni = |(m_pend & m_en);
         m_prev = m_s2[15:0];
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (reg_wr) begin
            case (reg_addr)
               0:  m_dir[31:0]  = reg_wdata;
               1:  m_dir[63:32] = reg_wdata;
               2:  m_sel[31:0]  = reg_wdata;
               3:  m_sel[63:32] = reg_wdata;
               4:  m_out[31:0]  = reg_wdata;
               5:  m_out[63:32] = reg_wdata;
               8:  m_edge = reg_wdata[15:0];
               9:  m_hi   = reg_wdata[15:0];
               10: m_lo   = reg_wdata[15:0];
               11: m_clr  = reg_wdata[15:0];
               12: m_en   = reg_wdata[15:0];
               default: ;
            endcase
         end
         m_pend = np;
         m_irq = ni;
      end
   end

   function automatic logic [31:0] model_rd(input logic [3:0] a);
      case (a)
         0:  return m_dir[31:0];
         1:  return m_dir[63:32];
         2:  return m_sel[31:0];
         3:  return m_sel[63:32];
         4:  return m_out[31:0];
         5:  return m_out[63:32];
         6:  return m_s2[31:0];
         7:  return m_s2[63:32];
         8:  return {16'h0, m_edge};
         9:  return {16'h0, m_hi};
         10: return {16'h0, m_lo};
         11: return {16'h0, m_clr};
         12: return {16'h0, m_en};
         13: return {16'h0, m_pend};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] a);
      case (a)
         6, 7:     return "R5";
         8, 9, 10: return "R7";
         11:       return "R8";
         12:       return "R9";
         13:       return "R11";
         14, 15:   return "R11";
         default:  return "R1";
      endcase
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2", "pin_oe", pin_oe, m_dir);
         chk("R3", "alt_sel", alt_sel, m_sel);
         chk("R4", "pin_out", pin_out, m_out);
         chk("R9", "irq", {63'h0, irq}, {63'h0, m_irq});
         chk(req_of(reg_addr), "rdata", {32'h0, reg_rdata}, {32'h0, model_rd(reg_addr)});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #2;
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      @(posedge clk); #2;
      reg_addr = a;
      @(negedge clk);
      chk(req, "read", {32'h0, reg_rdata}, {32'h0, exp});
   endtask

   task automatic pins(input logic [63:0] v);
      @(posedge clk); #2;
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic irq_chk(input string req, input logic exp);
      @(negedge clk);
      chk(req, "irq", {63'h0, irq}, {63'h0, exp});
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      idle(3);
      #2 rst_n = 1'b1;
      // R10 / R2 / R3: reset state
      for (int a = 0; a < 16; a++) rd_chk("R10", 4'(a), 32'h0);
      irq_chk("R10", 1'b0);

      // R1 / R2: second bank direction
      wr(4'd1, 32'h8000_0001);
      @(negedge clk);
      chk("R1", "pin_oe", pin_oe, 64'h8000_0001_0000_0000);
      // R3: select
      wr(4'd2, 32'h0000_00A5);
      @(negedge clk);
      chk("R3", "alt_sel", alt_sel, 64'h0000_0000_0000_00A5);
      // R4: output data
      wr(4'd5, 32'h1234_5678);
      wr(4'd4, 32'hCAFE_0001);
      @(negedge clk);
      chk("R4", "pin_out", pin_out, 64'h1234_5678_CAFE_0001);

      // R5: synchronized input, writes ignored
      pins(64'hDEAD_BEEF_0123_4567);
      idle(3);
      rd_chk("R5", 4'd6, 32'h0123_4567);
      rd_chk("R5", 4'd7, 32'hDEAD_BEEF);
      wr(4'd6, 32'h0);
      rd_chk("R5", 4'd6, 32'h0123_4567);
      wr(4'd13, 32'hFFFF);
      rd_chk("R11", 4'd13, 32'h0);
      rd_chk("R11", 4'd14, 32'h0);

      // R6: level-high on pin 3 (non-sticky)
      pins(64'h0);
      wr(4'd12, 32'hFFFF);
      wr(4'd9, 32'h0008);
      pins(64'h8);
      idle(4);
      irq_chk("R6", 1'b1);
      rd_chk("R6", 4'd13, 32'h0008);
      pins(64'h0);
      idle(4);
      rd_chk("R6", 4'd13, 32'h0);
      // R6: level-low on pin 2
      wr(4'd9, 32'h0);
      wr(4'd10, 32'h0004);
      idle(4);
      rd_chk("R6", 4'd13, 32'h0004);
      wr(4'd10, 32'h0);
      idle(2);

      // R7: rising edge on pin 5, sticky
      wr(4'd8, 32'h0020);
      wr(4'd9, 32'h0020);
      pins(64'h20);
      idle(4);
      pins(64'h0);
      idle(4);
      rd_chk("R7", 4'd13, 32'h0020);

      // R8: clear held blocks new events
      wr(4'd11, 32'h0020);
      rd_chk("R8", 4'd13, 32'h0);
      pins(64'h20);
      idle(4);
      rd_chk("R8", 4'd13, 32'h0);
      pins(64'h0);
      idle(4);
      wr(4'd11, 32'h0);
      idle(2);
      rd_chk("R8", 4'd13, 32'h0);

      // R7: falling on 6, both on 7, code 011 on 8 (none)
      wr(4'd8, 32'h00E0);
      wr(4'd9, 32'h01A0);
      wr(4'd10, 32'h01C0);
      pins(64'h1E0);
      idle(4);
      rd_chk("R7", 4'd13, 32'h00A0);
      pins(64'h0);
      idle(4);
      rd_chk("R7", 4'd13, 32'h00E0);
      rd_chk("R7", 4'd8, 32'h00E0);
      irq_chk("R9", 1'b1);

      // R9: enables gate the output
      wr(4'd12, 32'h0);
      idle(2);
      irq_chk("R9", 1'b0);

      // R8: clear-all sequence
      wr(4'd11, 32'hFFFF);
      wr(4'd11, 32'h0);
      rd_chk("R8", 4'd13, 32'h0);
      wr(4'd12, 32'hFFFF);
      idle(2);
      irq_chk("R9", 1'b0);

      // R10: reset in mid-operation
      @(posedge clk); #2 rst_n = 1'b0;
      idle(2);
      #2 rst_n = 1'b1;
      rd_chk("R10", 4'd8, 32'h0);
      rd_chk("R10", 4'd12, 32'h0);
      rd_chk("R10", 4'd1, 32'h0);
      irq_chk("R10", 1'b0);

      idle(2);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule